// File: doc/BRIEF.md
# Gigabit Transmit Data Scrambler

This block sits in the transmit path of a gigabit copper physical coding sublayer. Each clock it takes two nibbles from the side-stream generator, the transmit mode and the transmit-enable flag. From these it builds an 8-bit scrambler word. It then combines that word with the byte from the MAC and with the two delayed state bits of the convolutional encoder, which gives the 8-bit scrambled data word.

The mode has three meanings. Zeros mode drives both words to zero, for example during training. Idle mode always sends pure scrambler output. Normal mode sends idles or data, depending on the transmit-enable flag. In both idle cases the MAC byte and the encoder state have no effect, so idle symbols come only from the scrambler.

All eight scrambled bits go on to the symbol mapper. The top two bits also feed the convolutional encoder, and the encoder's delayed state comes back in on `enc_state`. Both outputs are registered, so they follow their inputs by one clock.

Top module: `tx_data_scrambler`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `scr_word` and `scr_data` are 8'h00.
- R2: When `mode` is 2'b01 (zeros) or 2'b11 (reserved, treated as zeros), `scr_word` and `scr_data` are 8'h00 one cycle later.
- R3: When `mode` is 2'b10 (normal) and `tx_en` is 1, `scr_word` is {`side_x`[3:0], `side_y`[3:0]} one cycle later, with `side_x` in bits 7:4.
- R4: In the data case of R3, `scr_data`[5:0] is `txd`[5:0] XOR `scr_word`[5:0].
- R5: In the data case of R3, `scr_data`[7] is `txd`[7] XOR `side_x`[3] XOR `enc_state`[1], and `scr_data`[6] is `txd`[6] XOR `side_x`[2] XOR `enc_state`[0].
- R6: In idle mode (`mode` 2'b00, whatever `tx_en` is), and in normal mode with `tx_en` at 0, `scr_word` is {4'h0, `side_y`} one cycle later and `scr_data` equals `scr_word`. In these cases `txd` and `enc_state` have no effect.
- R7: The outputs change only at a rising clock edge. New inputs applied between edges do not appear on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| side_x | input | 4 | Side-stream nibble for the upper scrambler bits |
| side_y | input | 4 | Side-stream nibble for the lower scrambler bits |
| mode | input | 2 | 00 idle, 01 zeros, 10 normal, 11 reserved (acts as zeros) |
| tx_en | input | 1 | High while a frame is being sent |
| enc_state | input | 2 | Delayed convolutional-encoder state bits |
| txd | input | 8 | Byte from the MAC |
| scr_word | output | 8 | Registered scrambler word |
| scr_data | output | 8 | Registered scrambled data word |

## Verification
The bench sweeps every combination of mode, enable, encoder state and both side-stream nibbles. A moving MAC byte runs under the sweep, so that three cases can be told apart: a byte that leaks into an idle or zeros cycle, a wrong nibble order in the scrambler word, and an encoder bit applied to the wrong upper data bit. The reserved mode code is included, which separates a design that decodes the reserved code as zeros from one that decodes it as idle or normal. Between clock edges the outputs are also sampled just after the inputs change, and this catches any path that bypasses the output registers.

// File: rtl/tx_data_scrambler.sv
module tx_data_scrambler #(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIB-1:0] side_x,
  input  logic [NIB-1:0] side_y,
  input  logic [1:0]     mode,
  input  logic           tx_en,
  input  logic [1:0]     enc_state,
  input  logic [2*NIB-1:0] txd,
  output logic [2*NIB-1:0] scr_word,
  output logic [2*NIB-1:0] scr_data
);
  localparam int W = 2*NIB;
  localparam logic [1:0] M_IDLE = 2'b00;
  localparam logic [1:0] M_NORM = 2'b10;

  logic          zero_m, data_m;
  logic [W-1:0]  sc_n, sd_n;

  assign zero_m = mode[0];
  assign data_m = (mode == M_NORM) && tx_en;

  assign sc_n = zero_m ? '0 : {(data_m ? side_x : {NIB{1'b0}}), side_y};
  assign sd_n = zero_m ? '0 :
                data_m ? (txd ^ sc_n ^ {enc_state, {(W-2){1'b0}}}) : sc_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_word <= '0;
      scr_data <= '0;
    end else begin
      scr_word <= sc_n;
      scr_data <= sd_n;
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (scr_word == '0 && scr_data == '0));

  a_r2_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0]) |=> (scr_word == '0 && scr_data == '0));

  a_r3_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && tx_en) |=> (scr_word == {$past(side_x), $past(side_y)}));

  a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && tx_en) |=>
      (scr_data[W-3:0] == ($past(txd[W-3:0]) ^ scr_word[W-3:0])));

  a_r5_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && tx_en) |=>
      (scr_data[W-1:W-2] == ($past(txd[W-1:W-2]) ^ scr_word[W-1:W-2] ^ $past(enc_state))));

  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE || (mode == M_NORM && !tx_en)) |=>
      (scr_data == scr_word && scr_word == {{NIB{1'b0}}, $past(side_y)}));

endmodule

// File: tb/tx_data_scrambler_bench.sv
`timescale 1ns/1ps
module tx_data_scrambler_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] side_x = 0, side_y = 0;
  logic [1:0] mode = 0;
  logic       tx_en = 0;
  logic [1:0] enc_state = 0;
  logic [7:0] txd = 0;
  logic [7:0] scr_word, scr_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_data_scrambler u_tx_data_scrambler (
    .clk(clk), .rst_n(rst_n), .side_x(side_x), .side_y(side_y), .mode(mode),
    .tx_en(tx_en), .enc_state(enc_state), .txd(txd),
    .scr_word(scr_word), .scr_data(scr_data));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [7:0] e_sc, e_sd;
    string tag_w, tag_d;
    repeat (3) @(negedge clk);
    chk("R1 word", scr_word, 8'h00);
    chk("R1 data", scr_data, 8'h00);
    mode = 2'b10; tx_en = 1; side_x = 4'hF; side_y = 4'hF; txd = 8'hA5;
    @(negedge clk);
    rst_n = 1;
    chk("R1 word held", scr_word, 8'h00);
    chk("R1 data held", scr_data, 8'h00);
    e_sc = 0; e_sd = 0; tag_w = "R1"; tag_d = "R1";
    for (int i = 0; i < 8192; i++) begin
      logic zm, dm;
      mode      = i[1:0];
      tx_en     = i[2];
      enc_state = i[4:3];
      side_x    = i[8:5];
      side_y    = i[12:9];
      txd       = 8'((i * 73 + 5) ^ (i >> 5));
      #1;
      chk("R7 word", scr_word, e_sc);
      chk("R7 data", scr_data, e_sd);
      zm = mode[0];
      dm = (mode == 2'b10) && tx_en;
      e_sc = zm ? 8'h00 : {(dm ? side_x : 4'h0), side_y};
      e_sd = zm ? 8'h00 : dm ? (txd ^ e_sc ^ {enc_state, 6'b0}) : e_sc;
      tag_w = zm ? "R2" : dm ? "R3" : "R6";
      tag_d = zm ? "R2" : dm ? "R4 R5" : "R6";
      @(negedge clk);
      chk(tag_w, scr_word, e_sc);
      chk(tag_d, scr_data, e_sd);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (50000) @(posedge clk); checks++; fails++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule